// File: doc/BRIEF.md
# Two-Hop Retransmission Recovery Buffer

This block sits beside one output link of a mesh router. It keeps a copy of every message at the moment the message is handed to the link, and holds that copy until delivery is confirmed. Each accepted message gets a sequence tag. Release depends on the fate of the message at the neighbor. A message that the neighbor consumes is freed by a first-level acknowledgement. A message that the neighbor relays onward is freed only by a second-level acknowledgement, which comes back from the router one hop beyond the neighbor. Because of this, a copy survives a hard failure of the adjacent router. Acknowledgements can arrive in any order. Freed slots are used again.

When recovery is requested, the block replays every retained message into the output queue, one per cycle, in the order the messages were first sent. Each replayed entry is dropped from the buffer. A one-cycle done flag ends the replay. Duplicates downstream are accepted as part of recovery. Capacity comes from the number of input and output buffer slots in the surrounding routers, with some extra room for messages still on the wire.

Top module: `relay_retain_buf`

## Requirements
- R1: After reset, `snd_ready` is 1, `snd_tag` is 0, and `rp_valid`, `rp_done` and `ack_err` are 0.
- R2: A message is accepted on a cycle where `snd_valid` and `snd_ready` are both high. It is stored under the tag shown on `snd_tag` in that cycle. `snd_tag` then steps by one, modulo 2^TAG_W, and holds its value when nothing is accepted.
- R3: When DEPTH entries are live, `snd_ready` is 0 and no send is accepted.
- R4: A first-level acknowledgement (`ack_lvl2`=0) that names a live entry sent with `snd_relay`=0 frees that entry, and `ack_err` stays 0.
- R5: A first-level acknowledgement that names a live entry sent with `snd_relay`=1 frees nothing and raises no error. A second-level acknowledgement (`ack_lvl2`=1) for that entry frees it.
- R6: An acknowledgement frees nothing and pulses `ack_err` high in the cycle after it is presented if it names a tag that is not live, or if it is second-level and names an entry sent with `snd_relay`=0.
- R7: Entries can be freed in any order, and the freed slots take new sends until the buffer is full again.
- R8: When `rec_req` is high in idle, the block starts a replay in the next cycle. It then presents one live entry per cycle on `rp_valid`/`rp_tag`/`rp_data`, oldest send first, and removes each entry as it is presented.
- R9: The cycle after the last replayed entry, or the first replay cycle if the buffer is empty, has `rp_done`=1 and `rp_valid`=0. The block is idle again in the next cycle.
- R10: During a replay, `snd_ready` is 0 and acknowledgements are ignored. They free nothing and raise no error.
- R11: While a live entry holds the tag that `snd_tag` would assign next, `snd_ready` is 0, even if free slots remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | A message is being driven onto the link |
| snd_data | input | DATA_W | Message contents to retain |
| snd_relay | input | 1 | 1 = the neighbor forwards this message, so it needs a second-level acknowledgement |
| snd_ready | output | 1 | Buffer can take a copy this cycle |
| snd_tag | output | TAG_W | Tag assigned to a send accepted this cycle |
| ack_valid | input | 1 | Acknowledgement present |
| ack_lvl2 | input | 1 | 0 = from the neighbor, 1 = from two hops downstream |
| ack_tag | input | TAG_W | Tag being acknowledged |
| ack_err | output | 1 | Previous cycle's acknowledgement matched nothing it may free |
| rec_req | input | 1 | Request a replay of all retained messages |
| rp_valid | output | 1 | Replayed message present |
| rp_data | output | DATA_W | Replayed message contents |
| rp_tag | output | TAG_W | Tag of the replayed message |
| rp_done | output | 1 | Replay finished (one-cycle pulse) |

## Verification
Some properties are checked on every cycle by assertions: the buffer never accepts a send when it is full or when the next tag is still live, the tag counter moves only on an accepted send, each replay cycle removes exactly one entry, replay blocks new sends, done never overlaps a replayed message, and acknowledgements during replay raise no error. Other behaviour only shows up in the scenarios. This includes which acknowledgement level frees which kind of entry, whether the error pulse fires for a wrong level versus a dead tag, slot reuse after out-of-order release, and the exact oldest-first order and contents of a replay. It also includes the proof that an acknowledgement during replay did not free anything, which is seen when that entry still comes out later in the replay.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

   typedef enum logic {
      RB_IDLE   = 1'b0,
      RB_REPLAY = 1'b1
   } rb_mode_e;

   function automatic int rrb_addr_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rrb_slot_store.sv
module rrb_slot_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   parameter int TAG_W  = 4,
   parameter int AW     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [AW-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic                          wr_relay,
   input  logic [DEPTH-1:0]              clr_vec,
   output logic [DEPTH-1:0]              valid_o,
   output logic [DEPTH-1:0][TAG_W-1:0]   tag_o,
   output logic [DEPTH-1:0]              relay_o,
   output logic [DEPTH-1:0][DATA_W-1:0]  data_o
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic wr_hit;
      assign wr_hit = wr_en && (wr_idx == AW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_o[g] <= 1'b0;
         end else if (wr_hit) begin
            valid_o[g] <= 1'b1;
         end else if (clr_vec[g]) begin
            valid_o[g] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_hit) begin
            tag_o[g]   <= wr_tag;
            relay_o[g] <= wr_relay;
            data_o[g]  <= wr_data;
         end
      end
   end

endmodule

// File: rtl/rrb_free_pick.sv
module rrb_free_pick #(
   parameter int DEPTH = 8,
   parameter int AW    = 3
) (
   input  logic [DEPTH-1:0] valid_i,
   output logic [AW-1:0]    free_idx,
   output logic             any_free
);

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_i[i]) free_idx = AW'(i);
      end
   end

   assign any_free = ~&valid_i;

endmodule

// File: rtl/rrb_tag_match.sv
module rrb_tag_match #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 4
) (
   input  logic [DEPTH-1:0]             valid_i,
   input  logic [DEPTH-1:0][TAG_W-1:0]  tag_i,
   input  logic [TAG_W-1:0]             key_i,
   output logic [DEPTH-1:0]             match_vec
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_vec[g] = valid_i[g] && (tag_i[g] == key_i);
   end

endmodule

// File: rtl/rrb_oldest_pick.sv
module rrb_oldest_pick #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 4,
   parameter int AW    = 3
) (
   input  logic [DEPTH-1:0]             valid_i,
   input  logic [DEPTH-1:0][TAG_W-1:0]  tag_i,
   input  logic [TAG_W-1:0]             next_tag,
   output logic [AW-1:0]                old_idx,
   output logic                         any_o
);

   logic [DEPTH:0][TAG_W-1:0] best_d;
   logic [DEPTH:0][AW-1:0]    best_i;
   logic [DEPTH:0]            best_v;

   assign best_d[0] = '0;
   assign best_i[0] = '0;
   assign best_v[0] = 1'b0;

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [TAG_W-1:0] age;
      logic             take;
      assign age  = next_tag - tag_i[g];
      assign take = valid_i[g] && (!best_v[g] || (age > best_d[g]));
      assign best_d[g+1] = take ? age : best_d[g];
      assign best_i[g+1] = take ? AW'(g) : best_i[g];
      assign best_v[g+1] = best_v[g] | valid_i[g];
   end

   assign old_idx = best_i[DEPTH];
   assign any_o   = best_v[DEPTH];

endmodule

// File: rtl/relay_retain_buf.sv
module relay_retain_buf
   import rrb_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int TAG_W     = 4,
   parameter int IN_MSGS   = 1,
   parameter int OUT_MSGS  = 0,
   parameter int WIRE_MSGS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snd_valid,
   input  logic [DATA_W-1:0] snd_data,
   input  logic              snd_relay,
   output logic              snd_ready,
   output logic [TAG_W-1:0]  snd_tag,
   input  logic              ack_valid,
   input  logic              ack_lvl2,
   input  logic [TAG_W-1:0]  ack_tag,
   output logic              ack_err,
   input  logic              rec_req,
   output logic              rp_valid,
   output logic [DATA_W-1:0] rp_data,
   output logic [TAG_W-1:0]  rp_tag,
   output logic              rp_done
);

   localparam int DEPTH = 6 * IN_MSGS + 5 * OUT_MSGS + WIRE_MSGS;
   localparam int AW    = rrb_addr_bits(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("relay_retain_buf: capacity must be at least two entries");
   end
   if (TAG_W <= AW) begin : g_bad_tag
      $error("relay_retain_buf: TAG_W must exceed the slot index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("relay_retain_buf: DATA_W must be positive");
   end

   rb_mode_e                    mode_q;
   logic [TAG_W-1:0]            seq_q;
   logic                        ack_err_q;

   logic [DEPTH-1:0]            slot_valid;
   logic [DEPTH-1:0][TAG_W-1:0] slot_tag;
   logic [DEPTH-1:0]            slot_relay;
   logic [DEPTH-1:0][DATA_W-1:0] slot_data;

   logic [AW-1:0]               free_idx;
   logic                        any_free;
   logic [DEPTH-1:0]            ack_match;
   logic [DEPTH-1:0]            seq_match;
   logic [DEPTH-1:0]            ack_hit;
   logic                        ack_quiet;
   logic [AW-1:0]               old_idx;
   logic                        any_live;

   logic                        in_idle;
   logic                        wr_en;
   logic                        ack_take;
   logic                        rp_fire;
   logic [DEPTH-1:0]            rp_onehot;
   logic [DEPTH-1:0]            clr_vec;

   rrb_slot_store #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W),
      .TAG_W (TAG_W),
      .AW    (AW)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (free_idx),
      .wr_data (snd_data),
      .wr_tag  (seq_q),
      .wr_relay(snd_relay),
      .clr_vec (clr_vec),
      .valid_o (slot_valid),
      .tag_o   (slot_tag),
      .relay_o (slot_relay),
      .data_o  (slot_data)
   );

   rrb_free_pick #(
      .DEPTH(DEPTH),
      .AW   (AW)
   ) i_free (
      .valid_i (slot_valid),
      .free_idx(free_idx),
      .any_free(any_free)
   );

   rrb_tag_match #(
      .DEPTH(DEPTH),
      .TAG_W(TAG_W)
   ) i_ack_cam (
      .valid_i  (slot_valid),
      .tag_i    (slot_tag),
      .key_i    (ack_tag),
      .match_vec(ack_match)
   );

   rrb_tag_match #(
      .DEPTH(DEPTH),
      .TAG_W(TAG_W)
   ) i_seq_cam (
      .valid_i  (slot_valid),
      .tag_i    (slot_tag),
      .key_i    (seq_q),
      .match_vec(seq_match)
   );

   rrb_oldest_pick #(
      .DEPTH(DEPTH),
      .TAG_W(TAG_W),
      .AW   (AW)
   ) i_age (
      .valid_i (slot_valid),
      .tag_i   (slot_tag),
      .next_tag(seq_q),
      .old_idx (old_idx),
      .any_o   (any_live)
   );

   assign in_idle = (mode_q == RB_IDLE);

   // Send side: stall while full, replaying, or while the next tag is still live
   assign snd_ready = in_idle && !rec_req && any_free && !(|seq_match);
   assign wr_en     = snd_valid && snd_ready;
   assign snd_tag   = seq_q;

   // Acknowledgements: level must agree with the relay flag of the entry
   assign ack_take  = ack_valid && in_idle;
   assign ack_hit   = ack_match & ~(slot_relay ^ {DEPTH{ack_lvl2}});
   assign ack_quiet = !ack_lvl2 && (|(ack_match & slot_relay));

   // Replay side
   assign rp_fire   = !in_idle && any_live;
   assign rp_onehot = {{(DEPTH-1){1'b0}}, 1'b1} << old_idx;
   assign clr_vec   = (ack_take ? ack_hit : '0) | (rp_fire ? rp_onehot : '0);

   assign rp_valid  = rp_fire;
   assign rp_done   = !in_idle && !any_live;
   assign rp_data   = slot_data[old_idx];
   assign rp_tag    = slot_tag[old_idx];
   assign ack_err   = ack_err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= RB_IDLE;
         seq_q     <= '0;
         ack_err_q <= 1'b0;
      end else begin
         ack_err_q <= ack_take && !(|ack_hit) && !ack_quiet;
         if (wr_en) seq_q <= seq_q + 1'b1;
         unique case (mode_q)
            RB_IDLE:   if (rec_req) mode_q <= RB_REPLAY;
            RB_REPLAY: if (!any_live) mode_q <= RB_IDLE;
            default:   mode_q <= RB_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rrb_checker.sv
module rrb_checker #(
   parameter int DEPTH = 8,
   parameter int TAG_W = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           snd_valid,
   input logic                           snd_ready,
   input logic [TAG_W-1:0]               snd_tag,
   input logic                           ack_valid,
   input logic                           ack_err,
   input logic                           rp_valid,
   input logic                           rp_done,
   input logic [DEPTH-1:0]               valid_vec,
   input logic [DEPTH-1:0][TAG_W-1:0]    tag_vec
);

   logic next_tag_live;
   always_comb begin
      next_tag_live = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (valid_vec[i] && (tag_vec[i] == snd_tag)) next_tag_live = 1'b1;
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      snd_ready |-> (int'($countones(valid_vec)) < DEPTH));

   p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && snd_ready) |=> (snd_tag == TAG_W'($past(snd_tag) + 1'b1)));

   p_tag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(snd_valid && snd_ready) |=> $stable(snd_tag));

   p_no_alias_r11: assert property (@(posedge clk) disable iff (!rst_n)
      next_tag_live |-> !snd_ready);

   p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rp_valid |=> (int'($countones(valid_vec)) == int'($countones($past(valid_vec))) - 1));

   p_replay_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_valid || rp_done) |-> !snd_ready);

   p_replay_ack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && (rp_valid || rp_done)) |=> !ack_err);

   p_done_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rp_done |-> !rp_valid);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rp_done |=> !rp_done && !rp_valid);

   p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_err |-> $past(ack_valid));

endmodule

bind relay_retain_buf rrb_checker #(
   .DEPTH(DEPTH),
   .TAG_W(TAG_W)
) i_rrb_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .snd_valid(snd_valid),
   .snd_ready(snd_ready),
   .snd_tag  (snd_tag),
   .ack_valid(ack_valid),
   .ack_err  (ack_err),
   .rp_valid (rp_valid),
   .rp_done  (rp_done),
   .valid_vec(slot_valid),
   .tag_vec  (slot_tag)
);

// File: tb/test_relay_retain_buf.sv
`timescale 1ns/1ps
module test_relay_retain_buf;

   localparam int DATA_W = 16;
   localparam int TAG_W  = 4;
   localparam int DEPTH  = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              snd_valid, snd_relay, snd_ready;
   logic [DATA_W-1:0] snd_data;
   logic [TAG_W-1:0]  snd_tag;
   logic              ack_valid, ack_lvl2, ack_err;
   logic [TAG_W-1:0]  ack_tag;
   logic              rec_req, rp_valid, rp_done;
   logic [DATA_W-1:0] rp_data;
   logic [TAG_W-1:0]  rp_tag;

   int n_run  = 0;
   int n_fail = 0;
   logic [TAG_W-1:0] exp_tag = '0;

   always #10 clk = ~clk;

   relay_retain_buf i_relay_retain_buf (
      .clk(clk), .rst_n(rst_n),
      .snd_valid(snd_valid), .snd_data(snd_data), .snd_relay(snd_relay),
      .snd_ready(snd_ready), .snd_tag(snd_tag),
      .ack_valid(ack_valid), .ack_lvl2(ack_lvl2), .ack_tag(ack_tag),
      .ack_err(ack_err), .rec_req(rec_req),
      .rp_valid(rp_valid), .rp_data(rp_data), .rp_tag(rp_tag), .rp_done(rp_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] dval(input logic [TAG_W-1:0] t);
      return 16'h5A00 | DATA_W'(t);
   endfunction

   task automatic do_send(input logic rl);
      snd_valid = 1'b1; snd_data = dval(exp_tag); snd_relay = rl;
      #1;
      chk(snd_ready == 1'b1, "R2", "ready before send", snd_ready, 1);
      chk(snd_tag == exp_tag, "R2", "assigned tag", snd_tag, exp_tag);
      @(posedge clk); #1;
      snd_valid = 1'b0;
      exp_tag = exp_tag + 1'b1;
   endtask

   task automatic do_ack(input logic [TAG_W-1:0] t, input logic lv2,
                         input logic exp_err, input string req);
      ack_valid = 1'b1; ack_tag = t; ack_lvl2 = lv2;
      @(posedge clk); #1;
      ack_valid = 1'b0;
      chk(ack_err == exp_err, req, "ack_err", ack_err, exp_err);
   endtask

   task automatic t_reset;
      chk(snd_ready == 1'b1, "R1", "reset ready", snd_ready, 1);
      chk(snd_tag == '0, "R1", "reset tag", snd_tag, 0);
      chk(!rp_valid && !rp_done, "R1", "reset replay", {rp_valid, rp_done}, 0);
      chk(ack_err == 1'b0, "R1", "reset err", ack_err, 0);
   endtask

   task automatic t_fill;
      for (int i = 0; i < DEPTH; i++) do_send(logic'(i % 2));
      #1;
      chk(snd_ready == 1'b0, "R3", "full stalls", snd_ready, 0);
      chk(snd_tag == 4'd8, "R2", "tag after fill", snd_tag, 8);
   endtask

   task automatic t_acks;
      do_ack(4'd3, 1'b0, 1'b0, "R5");
      chk(snd_ready == 1'b0, "R5", "ack1 keeps relayed", snd_ready, 0);
      do_ack(4'd2, 1'b1, 1'b1, "R6");
      chk(snd_ready == 1'b0, "R6", "wrong level frees nothing", snd_ready, 0);
      do_ack(4'd9, 1'b0, 1'b1, "R6");
      do_ack(4'd2, 1'b0, 1'b0, "R4");
      chk(snd_ready == 1'b1, "R4", "ack1 frees consumed", snd_ready, 1);
      do_ack(4'd2, 1'b0, 1'b1, "R6");
      do_ack(4'd3, 1'b1, 1'b0, "R5");
      do_send(1'b0);
      do_send(1'b0);
      #1;
      chk(snd_ready == 1'b0, "R7", "reused slots full again", snd_ready, 0);
      do_ack(4'd0, 1'b0, 1'b0, "R7");
      do_ack(4'd5, 1'b1, 1'b0, "R7");
   endtask

   task automatic t_replay;
      logic [TAG_W-1:0] order [6] = '{4'd1, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};
      rec_req = 1'b1;
      @(posedge clk); #1;
      rec_req = 1'b0;
      for (int k = 0; k < 6; k++) begin
         #1;
         chk(rp_valid == 1'b1, "R8", "replay valid", rp_valid, 1);
         chk(rp_tag == order[k], "R8", "replay order", rp_tag, order[k]);
         chk(rp_data == dval(order[k]), "R8", "replay data", rp_data, dval(order[k]));
         chk(snd_ready == 1'b0, "R10", "send blocked", snd_ready, 0);
         if (k == 0) begin
            ack_valid = 1'b1; ack_tag = 4'd4; ack_lvl2 = 1'b0;
         end
         @(posedge clk); #1;
         ack_valid = 1'b0;
         if (k == 0) chk(ack_err == 1'b0, "R10", "ack in replay no err", ack_err, 0);
      end
      chk(rp_done == 1'b1 && rp_valid == 1'b0, "R9", "done after last",
          {rp_done, rp_valid}, 2);
      @(posedge clk); #1;
      chk(rp_done == 1'b0 && snd_ready == 1'b1, "R9", "back to idle",
          {rp_done, snd_ready}, 1);
      do_ack(4'd1, 1'b1, 1'b1, "R8");
   endtask

   task automatic t_empty_replay;
      rec_req = 1'b1;
      @(posedge clk); #1;
      rec_req = 1'b0;
      chk(rp_done == 1'b1 && rp_valid == 1'b0, "R9", "empty replay done",
          {rp_done, rp_valid}, 2);
      @(posedge clk); #1;
      chk(snd_ready == 1'b1, "R9", "idle after empty", snd_ready, 1);
   endtask

   task automatic t_collision;
      logic [TAG_W-1:0] keep;
      keep = exp_tag;
      do_send(1'b1);
      for (int k = 0; k < 15; k++) begin
         logic [TAG_W-1:0] t;
         t = exp_tag;
         do_send(1'b0);
         do_ack(t, 1'b0, 1'b0, "R7");
      end
      #1;
      chk(snd_tag == keep, "R11", "tag wrapped", snd_tag, keep);
      chk(snd_ready == 1'b0, "R11", "stall on live tag", snd_ready, 0);
      do_ack(keep, 1'b1, 1'b0, "R11");
      chk(snd_ready == 1'b1, "R11", "ready once tag freed", snd_ready, 1);
   endtask

   initial begin
      rst_n = 1'b0; snd_valid = 1'b0; snd_relay = 1'b0; snd_data = '0;
      ack_valid = 1'b0; ack_lvl2 = 1'b0; ack_tag = '0; rec_req = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      t_reset;
      t_fill;
      t_acks;
      t_replay;
      t_empty_replay;
      t_collision;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule